// File: doc/BRIEF.md
# Serial Configuration EEPROM Bit-Bang Port

This block lets software drive 3-wire serial configuration EEPROMs one pin at a time through a small register bus. A register write sets the chip-select, clock and data-in levels, and a register read returns the level the EEPROM drives on its data-out line. Software sequences the whole EEPROM command protocol itself (start bit, opcode, address, shifting data) by issuing one write per pin change and one read per data bit sampled.

There are two ports. The mainboard port at one address drives a single EEPROM. The expansion-slot port at another address serves four slot EEPROMs. Each write to it carries a slot-select field next to the pin bits, so the same write that moves the pins also chooses which slot sees them. The slot port uses a different bit layout from the mainboard port. A slot with no EEPROM fitted reads back a high data-out level, as an undriven, pulled-up line would.

Top module: `seeprom_bitbang_port`

## Requirements
- R1: After reset every chip-select, clock and data-in output is low and the slot select is 0.
- R2: A write to the mainboard address sets the mainboard chip-select from write bit 0, its clock from bit 1 and its data-in from bit 2.
- R3: A read of the mainboard address returns the mainboard data-out level in bit 3, with every other bit 0.
- R4: A write to the slot address takes the slot number from write bits [1:0] and drives that slot's chip-select from bit 4, its clock from bit 2 and its data-in from bit 6, all in that one write.
- R5: Slots other than the selected one hold chip-select, clock and data-in low.
- R6: A read of the slot address returns the selected slot's data-out level in bit 7, with every other bit 0.
- R7: When the selected slot has no EEPROM present, bit 7 of a slot read is 1 whatever that slot's data-out pin shows.
- R8: Output pins change only on a write to their own port; writes to the other port or to any other address leave them as they were.
- R9: A read of any address other than the two port addresses returns 0.
- R10: A serial read command sequenced through either port by software recovers the 16-bit word an attached EEPROM shifts out, most significant bit first, after a low dummy bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address |
| mb_do | input | 1 | Mainboard EEPROM data-out |
| mb_cs | output | 1 | Mainboard EEPROM chip-select |
| mb_clk | output | 1 | Mainboard EEPROM clock |
| mb_di | output | 1 | Mainboard EEPROM data-in |
| slot_do | input | NSLOTS | Per-slot EEPROM data-out |
| slot_present | input | NSLOTS | Per-slot EEPROM fitted flag |
| slot_cs | output | NSLOTS | Per-slot chip-select |
| slot_clk | output | NSLOTS | Per-slot clock |
| slot_di | output | NSLOTS | Per-slot data-in |

## Verification
The state is a handful of pin registers and the slot select, so a wrong value shows at the pins in the cycle after the write that set it, and a wrong slot select shows both as the wrong slot toggling and as a slot read that returns another slot's data-out at once. A pin register that moves on a foreign write shows as a pin edge with no write to its port, which the hold checks catch in that same cycle. A slip anywhere in the bit layout breaks the end-to-end read, since the EEPROM model then sees a corrupt command and returns a different word.

// File: rtl/seeprom_bitbang_port.sv
module seeprom_bitbang_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int NSLOTS = 4,
  parameter logic [ADDR_W-1:0] MB_ADDR   = 'h0E,
  parameter logic [ADDR_W-1:0] SLOT_ADDR = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              mb_do,
  output logic              mb_cs,
  output logic              mb_clk,
  output logic              mb_di,
  input  logic [NSLOTS-1:0] slot_do,
  input  logic [NSLOTS-1:0] slot_present,
  output logic [NSLOTS-1:0] slot_cs,
  output logic [NSLOTS-1:0] slot_clk,
  output logic [NSLOTS-1:0] slot_di
);
  localparam int SEL_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;

  localparam int MB_CS_B = 0, MB_CLK_B = 1, MB_DI_B = 2, MB_DO_B = 3;
  localparam int SL_CS_B = 4, SL_CLK_B = 2, SL_DI_B = 6, SL_DO_B = 7;

  logic hit_mb, hit_slot, wr_mb, wr_slot;
  logic [2:0] mb_q, sl_q;
  logic [SEL_W-1:0] sel_q;
  logic sel_ok, sel_do;

  assign hit_mb   = (bus_addr == MB_ADDR);
  assign hit_slot = (bus_addr == SLOT_ADDR);
  assign wr_mb    = bus_wr && hit_mb;
  assign wr_slot  = bus_wr && hit_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mb_q  <= '0;
      sl_q  <= '0;
      sel_q <= '0;
    end else begin
      if (wr_mb)
        mb_q <= {bus_wdata[MB_DI_B], bus_wdata[MB_CLK_B], bus_wdata[MB_CS_B]};
      if (wr_slot) begin
        sl_q  <= {bus_wdata[SL_DI_B], bus_wdata[SL_CLK_B], bus_wdata[SL_CS_B]};
        sel_q <= bus_wdata[SEL_W-1:0];
      end
    end
  end

  assign mb_cs  = mb_q[0];
  assign mb_clk = mb_q[1];
  assign mb_di  = mb_q[2];

  for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
    logic picked;
    assign picked      = (sel_q == SEL_W'(i));
    assign slot_cs[i]  = picked & sl_q[0];
    assign slot_clk[i] = picked & sl_q[1];
    assign slot_di[i]  = picked & sl_q[2];
  end

  assign sel_ok = (int'(sel_q) < NSLOTS);
  assign sel_do = sel_ok ? (!slot_present[sel_q] || slot_do[sel_q]) : 1'b1;

  always_comb begin
    bus_rdata = '0;
    if (hit_mb)
      bus_rdata[MB_DO_B] = mb_do;
    else if (hit_slot)
      bus_rdata[SL_DO_B] = sel_do;
  end

  assert_mb_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mb |=> (mb_cs == $past(bus_wdata[MB_CS_B])) && (mb_clk == $past(bus_wdata[MB_CLK_B]))
              && (mb_di == $past(bus_wdata[MB_DI_B])));

  assert_slot_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slot && int'(bus_wdata[SEL_W-1:0]) < NSLOTS) |=>
      (slot_cs[$past(bus_wdata[SEL_W-1:0])] == $past(bus_wdata[SL_CS_B])) &&
      (slot_clk[$past(bus_wdata[SEL_W-1:0])] == $past(bus_wdata[SL_CLK_B])) &&
      (slot_di[$past(bus_wdata[SEL_W-1:0])] == $past(bus_wdata[SL_DI_B])));

  assert_one_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_cs | slot_clk | slot_di));

  assert_mb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mb |=> $stable({mb_cs, mb_clk, mb_di}));

  assert_slot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_slot |=> $stable({slot_cs, slot_clk, slot_di}));

  assert_quiet_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~(DATA_W'(1) << MB_DO_B) & ~(DATA_W'(1) << SL_DO_B)) == '0);

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_mb && !hit_slot) |-> (bus_rdata == '0));
endmodule

// File: tb/seeprom_bitbang_port_tb_top.sv
module seeprom_model #(parameter logic [15:0] SEED = 16'h0000) (
  input  logic cs,
  input  logic sck,
  input  logic di,
  output logic dout
);
  int cnt = 0;
  logic [8:0]  cmd = '0;
  logic [15:0] sh  = '0;
  initial dout = 1'b1;
  always @(posedge sck or negedge cs) begin
    if (!cs) begin
      cnt  = 0;
      dout = 1'b1;
    end else if (cnt < 9) begin
      cmd = {cmd[7:0], di};
      cnt++;
      if (cnt == 9) begin
        dout = 1'b0;
        sh   = SEED ^ {10'd0, cmd[5:0]};
      end
    end else begin
      dout = sh[15];
      sh   = {sh[14:0], 1'b0};
      cnt++;
    end
  end
endmodule

module seeprom_bitbang_port_tb_top;
  localparam logic [7:0] MB_A = 8'h0E, SL_A = 8'h10, NO_A = 8'h22;
  localparam logic [15:0] MB_SEED = 16'hA5C3, SL_SEED = 16'h3C96;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic mb_do, mb_cs, mb_clk, mb_di;
  logic [3:0] slot_do, slot_present, slot_cs, slot_clk, slot_di;
  logic m2_do, do0 = 1, do1 = 1, do3 = 1;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign slot_do = {do3, m2_do, do1, do0};

  seeprom_bitbang_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mb_do(mb_do),
    .mb_cs(mb_cs), .mb_clk(mb_clk), .mb_di(mb_di), .slot_do(slot_do),
    .slot_present(slot_present), .slot_cs(slot_cs), .slot_clk(slot_clk),
    .slot_di(slot_di));

  seeprom_model #(.SEED(MB_SEED)) mb_rom (.cs(mb_cs), .sck(mb_clk), .di(mb_di), .dout(mb_do));
  seeprom_model #(.SEED(SL_SEED)) sl_rom (.cs(slot_cs[2]), .sck(slot_clk[2]), .di(slot_di[2]), .dout(m2_do));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [15:0] pins(input bit slot, input int sel, input bit cs, input bit ck, input bit di);
    if (slot) return 16'((di << 6) | (cs << 4) | (ck << 2) | (sel & 3));
    return 16'((di << 2) | (ck << 1) | cs);
  endfunction

  function automatic logic [11:0] outs();
    return {slot_cs, slot_clk, slot_di};
  endfunction

  task automatic t_reset;
    logic [15:0] d;
    check("R1 mb pins", {mb_cs, mb_clk, mb_di}, 0);
    check("R1 slot pins", outs(), 0);
    do0 = 0;
    rd(SL_A, d);
    check("R1 sel is 0 (slot0 do=0)", d, 16'h0000);
    do0 = 1;
    rd(SL_A, d);
    check("R1 sel is 0 (slot0 do=1)", d, 16'h0080);
  endtask

  task automatic t_mb_pins;
    logic [15:0] d;
    wr(MB_A, 16'h0007);
    check("R2 all high", {mb_cs, mb_clk, mb_di}, 3'b111);
    wr(MB_A, 16'h0002);
    check("R2 clk only", {mb_cs, mb_clk, mb_di}, 3'b010);
    wr(MB_A, 16'hFFF8);
    check("R2 upper bits ignored", {mb_cs, mb_clk, mb_di}, 3'b000);
    check("R8 slot pins untouched by mb write", outs(), 0);
    rd(MB_A, d);
    check("R3 mb do idle high", d, 16'h0008);
  endtask

  task automatic t_slot_pins;
    wr(SL_A, pins(1, 1, 1, 1, 1));
    check("R4 slot1 cs", slot_cs, 4'b0010);
    check("R4 slot1 clk", slot_clk, 4'b0010);
    check("R4 slot1 di", slot_di, 4'b0010);
    wr(SL_A, pins(1, 3, 1, 0, 1));
    check("R5 cs moves to slot3", slot_cs, 4'b1000);
    check("R5 clk low everywhere", slot_clk, 4'b0000);
    check("R5 di slot3 only", slot_di, 4'b1000);
    wr(MB_A, 16'h0005);
    check("R8 slot pins hold on mb write", outs(), {4'b1000, 4'b0000, 4'b1000});
    wr(NO_A, 16'hFFFF);
    check("R8 slot pins hold on foreign write", outs(), {4'b1000, 4'b0000, 4'b1000});
    check("R8 mb pins hold on foreign write", {mb_cs, mb_clk, mb_di}, 3'b101);
    wr(SL_A, pins(1, 0, 0, 0, 0));
    check("R5 all slots low", outs(), 0);
  endtask

  task automatic t_slot_read;
    logic [15:0] d;
    wr(SL_A, pins(1, 0, 0, 0, 0));
    do0 = 0;
    rd(SL_A, d);
    check("R6 slot0 do low", d, 16'h0000);
    do0 = 1;
    rd(SL_A, d);
    check("R6 slot0 do high", d, 16'h0080);
    wr(SL_A, pins(1, 3, 0, 0, 0));
    do3 = 0;
    slot_present[3] = 0;
    rd(SL_A, d);
    check("R7 absent slot3 reads 1", d, 16'h0080);
    slot_present[3] = 1;
    rd(SL_A, d);
    check("R6 present slot3 do low", d, 16'h0000);
    rd(NO_A, d);
    check("R9 unmapped read", d, 16'h0000);
    rd(8'h0F, d);
    check("R9 neighbour address read", d, 16'h0000);
  endtask

  task automatic serial_read(input bit slot, input int sel, input logic [5:0] addr,
                             input logic [15:0] exp, input string tag);
    logic [8:0] cmd;
    logic [15:0] got, d;
    logic [7:0] a;
    int bitpos;
    a = slot ? SL_A : MB_A;
    bitpos = slot ? 7 : 3;
    cmd = {1'b1, 2'b10, addr};
    wr(a, pins(slot, sel, 1, 0, 0));
    for (int i = 8; i >= 0; i--) begin
      wr(a, pins(slot, sel, 1, 0, cmd[i]));
      wr(a, pins(slot, sel, 1, 1, cmd[i]));
      wr(a, pins(slot, sel, 1, 0, cmd[i]));
    end
    rd(a, d);
    check({tag, " dummy bit"}, d[bitpos], 0);
    got = '0;
    for (int i = 0; i < 16; i++) begin
      wr(a, pins(slot, sel, 1, 1, 0));
      rd(a, d);
      got = {got[14:0], d[bitpos]};
      wr(a, pins(slot, sel, 1, 0, 0));
    end
    wr(a, pins(slot, sel, 0, 0, 0));
    check({tag, " word"}, got, exp);
  endtask

  task automatic t_serial;
    serial_read(0, 0, 6'h15, MB_SEED ^ 16'h0015, "R10 mainboard");
    serial_read(1, 2, 6'h2A, SL_SEED ^ 16'h002A, "R10 slot2");
    serial_read(1, 2, 6'h01, SL_SEED ^ 16'h0001, "R10 slot2 again");
  endtask

  initial begin
    fork
      begin
        slot_present = 4'b1111;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_mb_pins();
        t_slot_pins();
        t_slot_read();
        t_serial();
      end
      begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule